// File: doc/BRIEF.md
# HI/LO multiply-divide unit

A multi-cycle arithmetic unit that holds a pair of 64-bit result registers, HI and LO, beside an integer pipeline. A one-cycle start pulse, a 4-bit operation code and two 64-bit operands launch one of eight operations: signed or unsigned multiply, and signed or unsigned divide, each in a 32-bit form or a 64-bit form. Two further codes copy the first operand straight into HI or LO. The current HI or LO can be read at any time through a read port. A read requested while a computation is in flight raises a stall output.

Multiplies are built from four registered 32x32 partial products, combined with column carries in a second cycle. The signed form multiplies magnitudes and negates the 128-bit result at the end. Divides are restoring, one quotient bit per cycle, on magnitudes. The quotient takes the XOR of the operand signs and the remainder takes the dividend's sign. A divisor of zero makes the start a no-op.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, HI and LO read as zero and busy is low.
- R2: Op code 8 copies opa into HI and op code 9 copies opa into LO, at the accepting clock edge, without raising busy.
- R3: mf_data shows HI when mf_sel is 1 and LO when mf_sel is 0. stall is high exactly when mf_req is high while busy is high.
- R4: Op codes 0 (signed) and 1 (unsigned) multiply the low 32 bits of the operands; the unsigned form zero-extends them. Bits 63:32 of the 64-bit product go to HI and bits 31:0 go to LO, each sign-extended from its bit 31.
- R5: Op codes 4 (signed) and 5 (unsigned) form the full 128-bit product of the 64-bit operands. The high half goes to HI and the low half to LO. A signed result is negated correctly, including a carry into HI when LO is zero.
- R6: After a multiply is accepted, busy is high for exactly one cycle. The result is readable in the cycle busy falls.
- R7: Op codes 2 (signed) and 3 (unsigned) divide the low 32 bits of opa by the low 32 bits of opb. The quotient goes to LO and the remainder to HI, both sign-extended from bit 31. A signed quotient truncates toward zero and the remainder takes the dividend's sign.
- R8: Op codes 6 (signed) and 7 (unsigned) divide the 64-bit operands, quotient to LO and remainder to HI, with the same sign rules as R7.
- R9: After a nonzero-divisor divide is accepted, busy is high for 33 cycles in the 32-bit form and 65 cycles in the 64-bit form. HI and LO change only at the end.
- R10: A divide whose divisor is zero (low 32 bits for codes 2 and 3, all 64 bits for codes 6 and 7) leaves HI and LO unchanged and never raises busy.
- R11: A start pulse while busy is high is ignored, whatever its op code.
- R12: Op codes 10 to 15, and cycles without start, leave HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled when idle |
| op | input | 4 | Operation code |
| opa | input | 64 | First operand (dividend, multiplicand, move source) |
| opb | input | 64 | Second operand (divisor, multiplier) |
| mf_req | input | 1 | Read request for HI/LO |
| mf_sel | input | 1 | Read select: 1 = HI, 0 = LO |
| mf_data | output | 64 | Current HI or LO |
| busy | output | 1 | Computation in flight |
| stall | output | 1 | Read requested while busy |

## Verification
The multiplies are tried with small mixed-sign values, with all-ones operands in both signed and unsigned forms, and with junk in the unused upper operand bits of the 32-bit forms. These patterns separate zero extension from sign extension and show whether the upper operand bits are ignored. The 64-bit signed multiplies cover one negative operand, two negative operands, the most negative value squared, and a product whose low half is zero, which exercises the carry into HI. The divides use every sign combination and the overflowing most-negative-by-minus-one case. Zero divisors include one whose upper half is nonzero, which separates the 32-bit zero test from the 64-bit one. The busy length is counted on every operation. Starts are also pulsed in the middle of a long divide to show they are ignored.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    localparam int XLEN = 64;
    localparam int OPW  = 4;

    // bit 3 clear: arithmetic; bit 2: 64-bit form; bit 1: divide; bit 0: unsigned
    typedef enum logic [OPW-1:0] {
        OP_MULT   = 4'd0,
        OP_MULTU  = 4'd1,
        OP_DIV    = 4'd2,
        OP_DIVU   = 4'd3,
        OP_DMULT  = 4'd4,
        OP_DMULTU = 4'd5,
        OP_DDIV   = 4'd6,
        OP_DDIVU  = 4'd7,
        OP_MTHI   = 4'd8,
        OP_MTLO   = 4'd9
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV
    } md_state_e;

    typedef struct packed {
        logic arith;
        logic wide;
        logic div;
        logic uns;
        logic mt_hi;
        logic mt_lo;
    } md_dec_t;

    function automatic md_dec_t md_decode(input logic [OPW-1:0] code);
        md_dec_t d;
        d.arith = ~code[3];
        d.wide  = code[2];
        d.div   = code[1];
        d.uns   = code[0];
        d.mt_hi = (code == OP_MTHI);
        d.mt_lo = (code == OP_MTLO);
        return d;
    endfunction

endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         negate,
    input  logic [W-1:0] a_mag,
    input  logic [W-1:0] b_mag,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo
);
    localparam int H  = W / 2;
    localparam int NP = 4;

    logic [W-1:0] pp_d [NP];
    logic [W-1:0] pp_q [NP];
    logic         neg_q;

    // partial product g: low/high half of a by low/high half of b
    for (genvar g = 0; g < NP; g++) begin : g_pp
        assign pp_d[g] = W'(a_mag[(g % 2) * H +: H]) * W'(b_mag[(g / 2) * H +: H]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NP; i++) pp_q[i] <= '0;
            neg_q <= 1'b0;
        end else if (load) begin
            for (int i = 0; i < NP; i++) pp_q[i] <= pp_d[i];
            neg_q <= negate;
        end
    end

    // column sums with carries between 32-bit columns
    logic [H+1:0] col1, col2;
    logic [H-1:0] col3;
    logic [W-1:0] mag_hi, mag_lo;

    assign col1 = (H+2)'(pp_q[0][W-1:H]) + (H+2)'(pp_q[1][H-1:0]) + (H+2)'(pp_q[2][H-1:0]);
    assign col2 = (H+2)'(col1[H+1:H]) + (H+2)'(pp_q[1][W-1:H]) + (H+2)'(pp_q[2][W-1:H])
                + (H+2)'(pp_q[3][H-1:0]);
    assign col3 = H'(col2[H+1:H]) + pp_q[3][W-1:H];

    assign mag_lo = {col1[H-1:0], pp_q[0][H-1:0]};
    assign mag_hi = {col3, col2[H-1:0]};

    assign prod_lo = neg_q ? (~mag_lo + W'(1)) : mag_lo;
    assign prod_hi = neg_q ? (~mag_hi + W'(mag_lo == '0)) : mag_hi;

endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         wide,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         last,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int H  = W / 2;
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          act_q;
    logic [W:0]    trial;

    assign trial = {rem_q, quo_q[W-1]} - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (load) begin
            act_q <= 1'b1;
            den_q <= den;
            rem_q <= '0;
            quo_q <= wide ? num : {num[H-1:0], {H{1'b0}}};
            cnt_q <= wide ? CW'(W) : CW'(H);
        end else if (act_q) begin
            if (cnt_q != '0) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= {rem_q[W-2:0], quo_q[W-1]};
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
            end else begin
                act_q <= 1'b0;
            end
        end
    end

    assign last = act_q && (cnt_q == '0);
    assign quo  = quo_q;
    assign rem  = rem_q;

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
    import hilo_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic           mf_req,
    input  logic           mf_sel,
    output logic [W-1:0]   mf_data,
    output logic           busy,
    output logic           stall
);
    localparam int H = W / 2;

    md_state_e    state_q;
    logic [W-1:0] hi_q, lo_q;
    md_dec_t      dec;
    logic         accept, a_neg, b_neg, den_zero, mul_load, div_load;
    logic [W-1:0] a_ext, b_ext, a_mag, b_mag;
    logic         narrow_q, qneg_q, rneg_q;
    logic [W-1:0] prod_hi, prod_lo, quo, rem, quo_s, rem_s;
    logic         div_last;

    function automatic logic [W-1:0] widen(input logic [H-1:0] v, input logic sgn);
        return {{H{sgn & v[H-1]}}, v};
    endfunction

    assign dec      = md_decode(op);
    assign accept   = start && (state_q == ST_IDLE);
    assign a_ext    = dec.wide ? opa : widen(opa[H-1:0], ~dec.uns);
    assign b_ext    = dec.wide ? opb : widen(opb[H-1:0], ~dec.uns);
    assign a_neg    = ~dec.uns & a_ext[W-1];
    assign b_neg    = ~dec.uns & b_ext[W-1];
    assign a_mag    = a_neg ? (~a_ext + W'(1)) : a_ext;
    assign b_mag    = b_neg ? (~b_ext + W'(1)) : b_ext;
    assign den_zero = (b_ext == '0);
    assign mul_load = accept && dec.arith && !dec.div;
    assign div_load = accept && dec.arith && dec.div && !den_zero;

    hilo_mul #(.W(W)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .load    (mul_load),
        .negate  (a_neg ^ b_neg),
        .a_mag   (a_mag),
        .b_mag   (b_mag),
        .prod_hi (prod_hi),
        .prod_lo (prod_lo)
    );

    hilo_div #(.W(W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .load (div_load),
        .wide (dec.wide),
        .num  (a_mag),
        .den  (b_mag),
        .last (div_last),
        .quo  (quo),
        .rem  (rem)
    );

    assign quo_s = qneg_q ? (~quo + W'(1)) : quo;
    assign rem_s = rneg_q ? (~rem + W'(1)) : rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            hi_q     <= '0;
            lo_q     <= '0;
            narrow_q <= 1'b0;
            qneg_q   <= 1'b0;
            rneg_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        narrow_q <= ~dec.wide;
                        qneg_q   <= a_neg ^ b_neg;
                        rneg_q   <= a_neg;
                        if (dec.mt_hi) hi_q <= opa;
                        if (dec.mt_lo) lo_q <= opa;
                    end
                    if (mul_load)      state_q <= ST_MUL;
                    else if (div_load) state_q <= ST_DIV;
                end
                ST_MUL: begin
                    if (narrow_q) begin
                        hi_q <= widen(prod_lo[W-1:H], 1'b1);
                        lo_q <= widen(prod_lo[H-1:0], 1'b1);
                    end else begin
                        hi_q <= prod_hi;
                        lo_q <= prod_lo;
                    end
                    state_q <= ST_IDLE;
                end
                ST_DIV: begin
                    if (div_last) begin
                        if (narrow_q) begin
                            hi_q <= widen(rem_s[H-1:0], 1'b1);
                            lo_q <= widen(quo_s[H-1:0], 1'b1);
                        end else begin
                            hi_q <= rem_s;
                            lo_q <= quo_s;
                        end
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign stall   = mf_req && busy;
    assign mf_data = mf_sel ? hi_q : lo_q;

endmodule

// File: rtl/hilo_checker.sv
module hilo_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [3:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         busy,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    localparam int H = W / 2;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hi_q == '0) && (lo_q == '0) && !busy);

    p_move_lo_r2: assert property (@(posedge clk) disable iff (rst)
        start && !busy && (op == 4'd9) |=> (lo_q == $past(opa)) && !busy);

    p_mul_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        start && !busy && !op[3] && !op[1] |=> busy ##1 !busy);

    p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy ##1 busy |-> $stable(hi_q) && $stable(lo_q));

    p_zero_divisor_r10: assert property (@(posedge clk) disable iff (rst)
        start && !busy && !op[3] && op[1]
        && ((op[2] && (opb == '0)) || (!op[2] && (opb[H-1:0] == '0)))
        |=> !busy && $stable(hi_q) && $stable(lo_q));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(hi_q) && $stable(lo_q));

endmodule

bind hilo_muldiv_unit hilo_checker #(.W(W)) i_hilo_checker (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .op    (op),
    .opa   (opa),
    .opb   (opb),
    .busy  (busy),
    .hi_q  (hi_q),
    .lo_q  (lo_q)
);

// File: tb/test_hilo_muldiv_unit.sv
module test_hilo_muldiv_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        mf_req = 1'b0, mf_sel = 1'b0;
    logic [63:0] mf_data;
    logic        busy, stall;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    hilo_muldiv_unit i_hilo_muldiv_unit (
        .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
        .mf_req(mf_req), .mf_sel(mf_sel), .mf_data(mf_data), .busy(busy), .stall(stall)
    );

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // behavioural reference: result and busy length of one operation
    function automatic void ref_calc(input logic [3:0] o, input logic [63:0] a, b,
                                     input logic [63:0] ph, pl,
                                     output logic [63:0] rh, rl, output int lat);
        logic [63:0]        p64;
        logic [127:0]       p128;
        logic signed [127:0] sa, sb;
        longint             x, y, q, r;
        logic [31:0]        uq, ur;
        logic signed [64:0] wx, wy, wq, wr;
        rh = ph; rl = pl; lat = 0;
        case (o)
            4'd0: begin
                p64 = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
                rh = sx(p64[63:32]); rl = sx(p64[31:0]); lat = 1;
            end
            4'd1: begin
                p64 = {32'd0, a[31:0]} * {32'd0, b[31:0]};
                rh = sx(p64[63:32]); rl = sx(p64[31:0]); lat = 1;
            end
            4'd4: begin
                sa = {{64{a[63]}}, a}; sb = {{64{b[63]}}, b};
                p128 = sa * sb;
                rh = p128[127:64]; rl = p128[63:0]; lat = 1;
            end
            4'd5: begin
                p128 = {64'd0, a} * {64'd0, b};
                rh = p128[127:64]; rl = p128[63:0]; lat = 1;
            end
            4'd2: if (b[31:0] != 0) begin
                x = longint'($signed(a[31:0])); y = longint'($signed(b[31:0]));
                q = x / y; r = x % y;
                rl = sx(q[31:0]); rh = sx(r[31:0]); lat = 33;
            end
            4'd3: if (b[31:0] != 0) begin
                uq = a[31:0] / b[31:0]; ur = a[31:0] % b[31:0];
                rl = sx(uq); rh = sx(ur); lat = 33;
            end
            4'd6: if (b != 0) begin
                wx = {a[63], a}; wy = {b[63], b};
                wq = wx / wy; wr = wx % wy;
                rl = wq[63:0]; rh = wr[63:0]; lat = 65;
            end
            4'd7: if (b != 0) begin
                rl = a / b; rh = a % b; lat = 65;
            end
            4'd8: rh = a;
            4'd9: rl = a;
            default: ;
        endcase
    endfunction

    // cycle model
    logic [63:0] m_hi, m_lo, m_phi, m_plo;
    int          m_cnt;

    always @(posedge clk) begin : model
        logic [63:0] h, l;
        int lt;
        if (rst) begin
            m_hi <= '0; m_lo <= '0; m_cnt <= 0;
        end else if (m_cnt != 0) begin
            if (m_cnt == 1) begin m_hi <= m_phi; m_lo <= m_plo; end
            m_cnt <= m_cnt - 1;
        end else if (start) begin
            ref_calc(op, opa, opb, m_hi, m_lo, h, l, lt);
            if (lt == 0) begin m_hi <= h; m_lo <= l; end
            else begin m_phi <= h; m_plo <= l; m_cnt <= lt; end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(posedge clk) begin : per_cycle
        #1;
        if (!rst) begin
            chk("R9 busy vs model", 64'(busy), 64'(m_cnt != 0));
            chk("R3 stall vs model", 64'(stall), 64'(mf_req && (m_cnt != 0)));
            chk("R3 mf_data vs model", mf_data, mf_sel ? m_hi : m_lo);
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin : watchdog
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL R9 watchdog actual=%0d expected=below 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic read_both(output logic [63:0] h, l);
        @(negedge clk);
        mf_sel = 1'b1; #1 h = mf_data;
        mf_sel = 1'b0; #1 l = mf_data;
    endtask

    task automatic do_op(input string tag, input string ltag,
                         input logic [3:0] o, input logic [63:0] a, b);
        logic [63:0] eh, el, gh, gl;
        int lat, c;
        ref_calc(o, a, b, m_hi, m_lo, eh, el, lat);
        @(negedge clk); op = o; opa = a; opb = b; start = 1'b1;
        @(negedge clk); start = 1'b0; c = 0;
        while (busy) begin c++; @(negedge clk); end
        chk({ltag, " busy cycles"}, 64'(c), 64'(lat));
        read_both(gh, gl);
        chk({tag, " HI"}, gh, eh);
        chk({tag, " LO"}, gl, el);
    endtask

    initial begin
        logic [63:0] h, l;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R1 LO after reset", mf_data, 64'd0);
        mf_sel = 1'b1; #1;
        chk("R1 HI after reset", mf_data, 64'd0);

        do_op("R2 move to HI", "R2", 4'd8, 64'h1122_3344_5566_7788, 64'h0);
        do_op("R2 move to LO", "R2", 4'd9, 64'h8877_6655_4433_2211, 64'h0);

        do_op("R4 signed 7*-3", "R6", 4'd0, 64'h7, 64'hFFFF_FFFF_FFFF_FFFD);
        do_op("R4 signed max*max junk upper", "R6", 4'd0, 64'hABCD_0000_7FFF_FFFF, 64'h1234_5678_7FFF_FFFF);
        do_op("R4 unsigned ones*ones", "R6", 4'd1, 64'h5555_0000_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF);
        do_op("R4 signed ones*ones", "R6", 4'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);

        do_op("R5 unsigned all ones", "R6", 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        do_op("R5 signed -5*3", "R6", 4'd4, 64'hFFFF_FFFF_FFFF_FFFB, 64'h3);
        do_op("R5 signed carry into HI", "R6", 4'd4, 64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000);
        do_op("R5 signed min*min", "R6", 4'd4, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        do_op("R5 signed -7*-9 wide", "R6", 4'd4, 64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFF7_0000_0000);
        do_op("R5 unsigned mixed", "R6", 4'd5, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);

        do_op("R7 signed -7/2", "R9", 4'd2, 64'hFFFF_FFF9, 64'h2);
        do_op("R7 signed 7/-2", "R9", 4'd2, 64'h7, 64'hFFFF_FFFE);
        do_op("R7 signed min/-1", "R9", 4'd2, 64'h8000_0000, 64'hFFFF_FFFF);
        do_op("R7 unsigned ones/3", "R9", 4'd3, 64'hFFFF_FFFF, 64'h3);
        do_op("R7 unsigned big/small", "R9", 4'd3, 64'h9999_8765_4321, 64'hFF00_0013);

        do_op("R8 signed -100/7", "R9", 4'd6, 64'hFFFF_FFFF_FFFF_FF9C, 64'h7);
        do_op("R8 signed min/-1", "R9", 4'd6, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        do_op("R8 signed big/-neg", "R9", 4'd6, 64'h7FFF_1234_5678_9ABC, 64'hFFFF_FFFF_FFF0_0001);
        do_op("R8 unsigned big/small", "R9", 4'd7, 64'hF123_4567_89AB_CDEF, 64'h1_0000_0003);
        do_op("R8 unsigned small/big", "R9", 4'd7, 64'h5, 64'hFFFF_FFFF_FFFF_FFFF);

        do_op("R10 DIV zero low half", "R10", 4'd2, 64'h55, 64'h0000_0001_0000_0000);
        do_op("R10 DIVU zero", "R10", 4'd3, 64'h55, 64'h0);
        do_op("R10 DDIV zero", "R10", 4'd6, 64'h55, 64'h0);
        do_op("R10 DDIVU zero", "R10", 4'd7, 64'h55, 64'h0);

        do_op("R12 undefined op 12", "R12", 4'd12, 64'hDEAD, 64'hBEEF);
        do_op("R12 undefined op 15", "R12", 4'd15, 64'hDEAD, 64'hBEEF);

        // starts while busy are ignored; stall follows read requests
        @(negedge clk); op = 4'd7; opa = 64'd1000; opb = 64'd7; start = 1'b1;
        @(negedge clk); start = 1'b0; mf_req = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 stall while busy", 64'(stall), 64'd1);
        op = 4'd9; opa = 64'hDEAD_BEEF; start = 1'b1;
        @(negedge clk); op = 4'd4; opa = 64'h3; opb = 64'h3;
        @(negedge clk); start = 1'b0;
        while (busy) @(negedge clk);
        #1;
        chk("R3 no stall when idle", 64'(stall), 64'd0);
        mf_req = 1'b0;
        read_both(h, l);
        chk("R11 HI after ignored starts", h, 64'd6);
        chk("R11 LO after ignored starts", l, 64'd142);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule